// File: doc/BRIEF.md
# Handshaked Memory Access Port

This block is one access port in front of a small synchronous word store. Four input docks feed it: a read address, a write address, a write data word and a burst descriptor. Each dock uses a four-phase request/acknowledge handshake. A single output dock returns every result, also with a four-phase handshake. The result carries a one-bit flag, so the consumer can tell read data from write completions.

The port works on one operation at a time. A read returns the addressed word with the flag at 0. A write needs both the address dock and the data dock. Once the word is stored, the port returns the address of the next word to write (address plus a fixed stride) with the flag at 1. A descriptor word holds a start address and a word count. It makes the port stream that many words from consecutive addresses out of the output dock, one handshake per word.

Top module: `memport_hs`

## Requirements
- R1: After synchronous active-low reset, every input acknowledge and `out_req` are 0.
- R2: A read request on an idle port is acknowledged on the first clock edge. On the next edge `out_req` rises, with `out_data` holding the word stored at `rd_addr` and `out_flag` at 0.
- R3: A write is accepted when both `wa_req` and `wd_req` are pending. Both acknowledges rise on the same edge as `out_req`. The word is stored, `out_data` is (`wa_addr` + STRIDE) mod 2^AW zero-extended, and `out_flag` is 1.
- R4: A write address without write data, or the reverse, is not acknowledged and produces no output.
- R5: A descriptor holds the start address in bits [DW-1:SZW], taken modulo 2^AW, and the word count in bits [SZW-1:0]. It produces that many outputs, each with flag 0, read from consecutive addresses that wrap at 2^AW. No further output follows.
- R6: A descriptor whose count field is 0 produces exactly one word.
- R7: A new operation is accepted only while the output dock is idle, meaning `out_req` and `out_ack` are both 0.
- R8: When several docks have new requests in the same cycle, the descriptor wins over the write, and the write wins over the read.
- R9: An acknowledge stays at 1 while its request stays at 1. It falls on the edge after the request is seen low. A request whose acknowledge is still high starts no new operation.
- R10: While `out_req` is 1 and `out_ack` is 0, `out_req`, `out_data` and `out_flag` stay unchanged. `out_req` falls on the edge where `out_ack` is seen at 1.
- R11: At most one operation starts per edge. While a burst is streaming, no read or write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read address dock request |
| rd_addr | input | AW | Read address |
| rd_ack | output | 1 | Read address dock acknowledge |
| wa_req | input | 1 | Write address dock request |
| wa_addr | input | AW | Write address |
| wa_ack | output | 1 | Write address dock acknowledge |
| wd_req | input | 1 | Write data dock request |
| wd_data | input | DW | Write data word |
| wd_ack | output | 1 | Write data dock acknowledge |
| cb_req | input | 1 | Descriptor dock request |
| cb_word | input | DW | Descriptor: start address above SZW, count below |
| cb_ack | output | 1 | Descriptor dock acknowledge |
| out_req | output | 1 | Output dock request |
| out_data | output | DW | Result word |
| out_flag | output | 1 | 0 for read data, 1 for write completion |
| out_ack | input | 1 | Output dock acknowledge from consumer |

## Verification
A wrong cursor or counter shows up as a wrong word or a wrong number of words within the next output handshake of a burst. A stuck controller state shows up within one or two edges as an acknowledge that never rises, or one that rises while the output is busy. A lost handshake register appears as `out_req` or an acknowledge that does not fall one edge after its partner changes. The bench counts latencies in edges and checks every returned word and flag against a model of the store. Any such fault therefore appears at the ports on the first operation that touches it.

// File: rtl/memport_pkg.sv
// Shared definitions for the handshaked memory port.
// Assumes: dock indices are used as bit positions in request/ack vectors.
package memport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_RD_WAIT     = 2'd1,
        ST_BURST_ISSUE = 2'd2,
        ST_BURST_WAIT  = 2'd3
    } mp_state_e;

    localparam int DOCK_RD = 0;
    localparam int DOCK_WA = 1;
    localparam int DOCK_WD = 2;
    localparam int DOCK_CB = 3;
    localparam int N_DOCKS = 4;
endpackage

// File: rtl/memport_ackdock.sv
// Acknowledge registers for the input docks, four-phase style.
// An ack is set by a take pulse and held until its request is seen low.
// Assumes: take is only asserted for a dock whose request is high.
module memport_ackdock #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] take,
    output logic [N-1:0] ack
);
    for (genvar i = 0; i < N; i++) begin : g_dock
        // Set on take, clear once the request has been withdrawn.
        always_ff @(posedge clk) begin
            if (!rst_n)       ack[i] <= 1'b0;
            else if (take[i]) ack[i] <= 1'b1;
            else if (!req[i]) ack[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/memport_store.sv
// Single-port synchronous word store with registered read data.
// Assumes: read and write enables are never high together (controller serializes).
module memport_store #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/memport_ctrl.sv
// Operation sequencer: picks one dock (descriptor > write > read) when the
// output dock is idle, drives the store, and runs the output handshake.
// Assumes: DW >= AW and DW >= SZW + AW.
module memport_ctrl
    import memport_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int SZW    = 3,
    parameter int STRIDE = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DOCKS-1:0] req,
    input  logic [N_DOCKS-1:0] ack,
    input  logic [AW-1:0]      rd_addr,
    input  logic [AW-1:0]      wa_addr,
    input  logic [DW-1:0]      wd_data,
    input  logic [DW-1:0]      cb_word,
    input  logic               out_ack,
    input  logic [DW-1:0]      q,
    output logic [N_DOCKS-1:0] take,
    output logic               we,
    output logic [AW-1:0]      waddr,
    output logic [DW-1:0]      wdata,
    output logic               re,
    output logic [AW-1:0]      raddr,
    output logic               out_req,
    output logic [DW-1:0]      out_data,
    output logic               out_flag
);
    localparam int DEPTH = 1 << AW;
    localparam int STW   = DW - SZW;

    mp_state_e      state;
    logic [AW-1:0]  cursor;
    logic [SZW-1:0] count, total;
    logic [SZW-1:0] cnt_nxt;
    logic [AW-1:0]  wr_next;
    logic [STW-1:0] cb_start;
    logic [SZW-1:0] cb_size;
    logic           out_idle, new_rd, new_wr, new_cb;

    assign out_idle = !out_req && !out_ack;
    assign new_rd   = req[DOCK_RD] && !ack[DOCK_RD];
    assign new_wr   = req[DOCK_WA] && !ack[DOCK_WA] && req[DOCK_WD] && !ack[DOCK_WD];
    assign new_cb   = req[DOCK_CB] && !ack[DOCK_CB];
    assign cb_start = cb_word[DW-1:SZW];
    assign cb_size  = cb_word[SZW-1:0];
    assign cnt_nxt  = count + SZW'(1);
    assign wr_next  = wa_addr + AW'(STRIDE);
    assign waddr    = wa_addr;
    assign wdata    = wd_data;

    // Choose the operation to start this cycle and drive the store.
    always_comb begin
        take  = '0;
        we    = 1'b0;
        re    = 1'b0;
        raddr = cursor;
        if (state == ST_IDLE && out_idle) begin
            if (new_cb) begin
                take[DOCK_CB] = 1'b1;
            end else if (new_wr) begin
                take[DOCK_WA] = 1'b1;
                take[DOCK_WD] = 1'b1;
                we            = 1'b1;
            end else if (new_rd) begin
                take[DOCK_RD] = 1'b1;
                re            = 1'b1;
                raddr         = rd_addr;
            end
        end else if (state == ST_BURST_ISSUE && out_idle) begin
            re = 1'b1;
        end
    end

    // Sequencer state, burst cursor/counter and output dock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cursor   <= '0;
            count    <= '0;
            total    <= '0;
            out_req  <= 1'b0;
            out_data <= '0;
            out_flag <= 1'b0;
        end else begin
            if (out_req && out_ack) out_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take[DOCK_CB]) begin
                        cursor <= AW'(cb_start % DEPTH);
                        count  <= '0;
                        total  <= (cb_size == '0) ? SZW'(1) : cb_size;
                        state  <= ST_BURST_ISSUE;
                    end else if (take[DOCK_WA]) begin
                        out_data <= DW'(wr_next);
                        out_flag <= 1'b1;
                        out_req  <= 1'b1;
                    end else if (take[DOCK_RD]) begin
                        state <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    out_data <= q;
                    out_flag <= 1'b0;
                    out_req  <= 1'b1;
                    state    <= ST_IDLE;
                end
                ST_BURST_ISSUE: begin
                    if (re) state <= ST_BURST_WAIT;
                end
                ST_BURST_WAIT: begin
                    out_data <= q;
                    out_flag <= 1'b0;
                    out_req  <= 1'b1;
                    cursor   <= cursor + AW'(1);
                    count    <= cnt_nxt;
                    state    <= (cnt_nxt == total) ? ST_IDLE : ST_BURST_ISSUE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/memport_hs.sv
// Handshaked memory access port: four four-phase input docks, one output
// dock, a sequencer and a synchronous word store.
// Assumes: consumers follow four-phase handshakes on every dock.
module memport_hs
    import memport_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int SZW    = 3,
    parameter int STRIDE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ack,
    input  logic          wa_req,
    input  logic [AW-1:0] wa_addr,
    output logic          wa_ack,
    input  logic          wd_req,
    input  logic [DW-1:0] wd_data,
    output logic          wd_ack,
    input  logic          cb_req,
    input  logic [DW-1:0] cb_word,
    output logic          cb_ack,
    output logic          out_req,
    output logic [DW-1:0] out_data,
    output logic          out_flag,
    input  logic          out_ack
);
    logic [N_DOCKS-1:0] dock_req, dock_ack, dock_take;
    logic               st_we, st_re;
    logic [AW-1:0]      st_waddr, st_raddr;
    logic [DW-1:0]      st_wdata, st_q;

    assign dock_req = {cb_req, wd_req, wa_req, rd_req};
    assign rd_ack   = dock_ack[DOCK_RD];
    assign wa_ack   = dock_ack[DOCK_WA];
    assign wd_ack   = dock_ack[DOCK_WD];
    assign cb_ack   = dock_ack[DOCK_CB];

    memport_ackdock #(.N(N_DOCKS)) u_docks (
        .clk(clk), .rst_n(rst_n), .req(dock_req), .take(dock_take), .ack(dock_ack)
    );

    memport_ctrl #(.DW(DW), .AW(AW), .SZW(SZW), .STRIDE(STRIDE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(dock_req), .ack(dock_ack),
        .rd_addr(rd_addr), .wa_addr(wa_addr), .wd_data(wd_data), .cb_word(cb_word),
        .out_ack(out_ack), .q(st_q), .take(dock_take),
        .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .re(st_re), .raddr(st_raddr),
        .out_req(out_req), .out_data(out_data), .out_flag(out_flag)
    );

    memport_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
        .re(st_re), .raddr(st_raddr), .q(st_q)
    );
endmodule

// File: rtl/memport_hs_chk.sv
// Protocol checker for memport_hs, attached by bind below.
// Assumes: only port-level signals are observed.
module memport_hs_chk #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_ack,
    input logic          wa_req,
    input logic          wa_ack,
    input logic          wd_req,
    input logic          wd_ack,
    input logic          cb_ack,
    input logic          out_req,
    input logic [DW-1:0] out_data,
    input logic          out_flag,
    input logic          out_ack
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> (out_req && $stable(out_data) && $stable(out_flag)));
    // R9
    rd_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_req) |=> rd_ack);
    // R9
    rd_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_req) |=> !rd_ack);
    // R3
    wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wa_ack) |-> ($rose(wd_ack) && out_req && out_flag));
    // R4
    wr_need_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wa_ack) |-> ($past(wd_req) && $past(wa_req)));
    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> !$past(out_ack));
    // R11
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({$rose(rd_ack), $rose(wa_ack), $rose(cb_ack)}) <= 1);
    // R2
    rd_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ack) |=> (out_req && !out_flag));
endmodule

bind memport_hs memport_hs_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
    .wa_req(wa_req), .wa_ack(wa_ack), .wd_req(wd_req), .wd_ack(wd_ack),
    .cb_ack(cb_ack), .out_req(out_req), .out_data(out_data),
    .out_flag(out_flag), .out_ack(out_ack)
);

// File: tb/memport_hs_test.sv
// Self-checking bench for memport_hs (DW=16, AW=4, SZW=3, STRIDE=1).
module memport_hs_test;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NV = 10;
    // {kind(0=write,1=read), addr, wdata, expected out_data, expected flag}
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 4'd3,  16'h1234, 16'h0004, 1'b1},
        {2'd0, 4'd15, 16'hBEEF, 16'h0000, 1'b1},
        {2'd0, 4'd0,  16'h0A0A, 16'h0001, 1'b1},
        {2'd0, 4'd14, 16'h5555, 16'h000F, 1'b1},
        {2'd1, 4'd3,  16'h0000, 16'h1234, 1'b0},
        {2'd1, 4'd15, 16'h0000, 16'hBEEF, 1'b0},
        {2'd1, 4'd0,  16'h0000, 16'h0A0A, 1'b0},
        {2'd0, 4'd3,  16'h7777, 16'h0004, 1'b1},
        {2'd1, 4'd3,  16'h0000, 16'h7777, 1'b0},
        {2'd1, 4'd14, 16'h0000, 16'h5555, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_req = 0, wa_req = 0, wd_req = 0, cb_req = 0, out_ack = 0;
    logic [AW-1:0] rd_addr = '0, wa_addr = '0;
    logic [DW-1:0] wd_data = '0, cb_word = '0;
    logic rd_ack, wa_ack, wd_ack, cb_ack, out_req, out_flag;
    logic [DW-1:0] out_data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    memport_hs uut (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_until_out();
        for (int i = 0; i < 50 && !out_req; i++) @(negedge clk);
    endtask

    task automatic take_out(input logic [DW-1:0] exp, input logic fl, input string tag);
        wait_until_out();
        chk(out_req, 1, tag);
        chk(out_data, exp, tag);
        chk(out_flag, fl, tag);
        out_ack = 1;
        @(negedge clk);
        chk(out_req, 0, {tag, " R10 drop"});
        out_ack = 0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        rd_addr = a; rd_req = 1;
        for (int i = 0; i < 50 && !rd_ack; i++) @(negedge clk);
        rd_req = 0;
        for (int i = 0; i < 50 && rd_ack; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wa_addr = a; wd_data = d; wa_req = 1; wd_req = 1;
        for (int i = 0; i < 50 && !wa_ack; i++) @(negedge clk);
        wa_req = 0; wd_req = 0;
        for (int i = 0; i < 50 && wa_ack; i++) @(negedge clk);
    endtask

    task automatic do_cb(input logic [DW-1:0] w);
        cb_word = w; cb_req = 1;
        for (int i = 0; i < 50 && !cb_ack; i++) @(negedge clk);
        cb_req = 0;
        for (int i = 0; i < 50 && cb_ack; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({rd_ack, wa_ack, wd_ack, cb_ack, out_req}, 0, "R1 reset");
        rst_n = 1;
        @(negedge clk);
        chk({rd_ack, wa_ack, wd_ack, cb_ack, out_req}, 0, "R1 after reset");

        // Table walk: R2 reads, R3 writes
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][38:37] == 2'd0) begin
                do_write(VEC[v][36:33], VEC[v][32:17]);
                take_out(VEC[v][16:1], VEC[v][0], "R3 table write");
            end else begin
                do_read(VEC[v][36:33]);
                take_out(VEC[v][16:1], VEC[v][0], "R2 table read");
            end
        end

        // R2: read latency, ack on first edge, result on second
        rd_addr = 4'd3; rd_req = 1;
        @(negedge clk);
        chk(rd_ack, 1, "R2 ack edge1");
        chk(out_req, 0, "R2 no output edge1");
        @(negedge clk);
        chk(out_req, 1, "R2 output edge2");
        chk(out_data, 16'h7777, "R2 data edge2");
        rd_req = 0;
        take_out(16'h7777, 0, "R2 latency read");

        // R4: write address alone does nothing
        wa_addr = 4'd9; wa_req = 1; wd_data = 16'h9999;
        repeat (4) @(negedge clk);
        chk({wa_ack, wd_ack, out_req}, 0, "R4 address only");
        wa_req = 0; wd_req = 1;
        repeat (4) @(negedge clk);
        chk({wa_ack, wd_ack, out_req}, 0, "R4 data only");
        // R3: completing the pair starts the write at once
        wa_req = 1;
        @(negedge clk);
        chk({wa_ack, wd_ack, out_req, out_flag}, 4'b1111, "R3 acks and output same edge");
        chk(out_data, 16'h000A, "R3 next address");
        wa_req = 0; wd_req = 0;
        take_out(16'h000A, 1, "R3 write 9");
        do_read(4'd9);
        take_out(16'h9999, 0, "R3 stored word");

        // R5: burst of 3 from 14 wraps to 0
        do_cb({9'd0, 4'd14, 3'd3});
        take_out(16'h5555, 0, "R5 burst word0");
        take_out(16'hBEEF, 0, "R5 burst word1");
        take_out(16'h0A0A, 0, "R5 burst word2");
        repeat (5) @(negedge clk);
        chk(out_req, 0, "R5 no extra word");

        // R6: zero count gives one word
        do_cb({9'd0, 4'd3, 3'd0});
        take_out(16'h7777, 0, "R6 zero count word");
        repeat (5) @(negedge clk);
        chk(out_req, 0, "R6 only one word");

        // R5: start field taken modulo depth (0x23 -> 3)
        do_cb({7'd0, 6'h23, 3'd1});
        take_out(16'h7777, 0, "R5 start modulo");

        // R8 / R11: descriptor wins over write and read
        cb_word = {9'd0, 4'd9, 3'd1}; cb_req = 1;
        wa_addr = 4'd5; wd_data = 16'h5A5A; wa_req = 1; wd_req = 1;
        rd_addr = 4'd9; rd_req = 1;
        @(negedge clk);
        chk({cb_ack, wa_ack, rd_ack}, 3'b100, "R8 descriptor first");
        cb_req = 0;
        wait_until_out();
        chk({wa_ack, rd_ack}, 0, "R11 none during burst");
        take_out(16'h9999, 0, "R8 burst word");
        for (int i = 0; i < 10 && !wa_ack; i++) @(negedge clk);
        chk({wa_ack, rd_ack}, 2'b10, "R8 write before read");
        wa_req = 0; wd_req = 0;
        take_out(16'h0006, 1, "R8 write result");
        for (int i = 0; i < 10 && !rd_ack; i++) @(negedge clk);
        chk(rd_ack, 1, "R8 read last");
        rd_req = 0;
        take_out(16'h9999, 0, "R8 read result");

        // R10 / R7: held output blocks new work
        do_read(4'd3);
        wa_addr = 4'd1; wd_data = 16'h1111; wa_req = 1; wd_req = 1;
        repeat (5) @(negedge clk);
        chk(out_req, 1, "R10 held req");
        chk(out_data, 16'h7777, "R10 held data");
        chk(wa_ack, 0, "R7 busy output");
        out_ack = 1;
        @(negedge clk);
        chk({out_req, wa_ack}, 0, "R7 ack still high");
        out_ack = 0;
        @(negedge clk);
        chk({wa_ack, out_req}, 2'b11, "R7 starts when idle");
        chk(out_data, 16'h0002, "R7 write result");
        wa_req = 0; wd_req = 0;
        take_out(16'h0002, 1, "R7 write consumed");

        // R9: held request is not re-accepted
        rd_addr = 4'd1; rd_req = 1;
        take_out(16'h1111, 0, "R9 first read");
        repeat (5) @(negedge clk);
        chk(rd_ack, 1, "R9 ack held");
        chk(out_req, 0, "R9 no second read");
        rd_req = 0;
        @(negedge clk);
        chk(rd_ack, 0, "R9 ack dropped");

        done = 1;
        summary();
        $finish;
    end
endmodule